// File: doc/BRIEF.md
# Serial Page Flash Read Slave

This block is the device side of a serial page-organised flash, restricted to its read path. A host drives a serial clock, an active-low select and a serial data line. The block answers on a serial output line that comes with an output enable for the pad's tri-state driver. Each command opens with an 8-bit opcode. Three opcodes are served: a direct read of a main-store page, a read of the single page-sized buffer, and a copy of one main-store page into that buffer. Opcodes, addresses and data all travel most significant bit first. Any other opcode leaves the block silent until select is released.

The serial pins are brought into the system clock domain through a short synchroniser. Input bits are taken on serial-clock rising edges. Output bits change after serial-clock falling edges. Reads never run past a page: after the last byte of a page or of the buffer, the next byte is byte 0 of the same page or buffer. The main store is filled through a preload stream that uses valid/ready. A beat moves when `pl_valid` and `pl_ready` are both high on a clock edge, and it carries one byte per clock at most. The source must hold `pl_addr` and `pl_data` steady while `pl_ready` is low. `pl_ready` drops for as long as a page-to-buffer copy is running, because the copy reads the main store.

Top module: `sflash_read_slave`

## Requirements
- R1: After reset `so_oe` is 0 and `pl_ready` is 1.
- R2: Input bits are taken on serial-clock rising edges, MSB first. `so_oe` stays 0 while command, address and dummy bits are being received. The first data bit (bit 7 of the first byte) is on `so`, with `so_oe` at 1, after the falling edge that follows the last dummy bit.
- R3: Opcode 0x52 reads the main store. After the opcode come 6 ignored bits, a 9-bit page field and a 9-bit byte offset, then 32 ignored dummy bits, then data. The page used is the page field modulo NUM_PAGES.
- R4: During a 0x52 read, the byte after offset PAGE_BYTES-1 is offset 0 of the same page.
- R5: A 0x52 byte offset of PAGE_BYTES or more is reduced modulo PAGE_BYTES before the read starts (264 reads as 0, 300 as 36, 511 as 247).
- R6: A 0x52 read leaves the buffer contents unchanged.
- R7: Opcode 0x54 reads the buffer. After the opcode come 15 ignored bits, a 9-bit buffer address and 8 ignored bits, then data. The read wraps from PAGE_BYTES-1 to 0.
- R8: Opcode 0x53 is followed by 6 ignored bits and a 9-bit page field. If select rises after at least 23 bits have followed the opcode, the whole page (page field modulo NUM_PAGES) is copied into the buffer.
- R9: If select rises on a 0x53 command before 23 bits have followed the opcode, the buffer is unchanged and no copy starts.
- R10: Any opcode other than 0x52, 0x53 or 0x54 produces no output (`so_oe` stays 0) for the rest of that select period.
- R11: A rising select ends a read and drives `so_oe` to 0. The next command is decoded afresh.
- R12: The preload stream writes `pl_data` to main-store byte `pl_addr` = page*PAGE_BYTES + offset whenever `pl_valid` and `pl_ready` are both high. `pl_ready` is 0 while a copy runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the `so` pad driver |
| pl_valid | input | 1 | Preload beat valid |
| pl_ready | output | 1 | Preload beat accepted when high |
| pl_addr | input | MEM_AW (11) | Preload byte address in the main store |
| pl_data | input | 8 | Preload byte |

## Verification
The bench uses the default parameters: 4 pages of 264 bytes and a two-stage synchroniser. At that size every byte of the main store can be preloaded with an arithmetic pattern, and every page can be swept at its start, middle and both sides of the wrap point. One full-length buffer read passes the wrap, and the offsets that the modulo rule folds are reached directly. Because the page count is small, the page-field modulo rule is also exercised, with a page field above the page count landing on a known page.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam int FIELD_W = 9;
  localparam int CNT_W   = 7;

  localparam logic [7:0] OP_PAGE_READ = 8'h52;
  localparam logic [7:0] OP_PAGE_COPY = 8'h53;
  localparam logic [7:0] OP_BUF_READ  = 8'h54;

  // bit counts (including the opcode) at which frame fields complete
  localparam logic [CNT_W-1:0] AT_OPCODE    = 7'd8;
  localparam logic [CNT_W-1:0] AT_PAGE      = 7'd23;
  localparam logic [CNT_W-1:0] AT_OFFSET    = 7'd32;
  localparam logic [CNT_W-1:0] AT_COPY_DONE = 7'd31;
  localparam logic [CNT_W-1:0] AT_PAGE_DATA = 7'd64;
  localparam logic [CNT_W-1:0] AT_BUF_DATA  = 7'd40;
  localparam logic [CNT_W-1:0] CNT_MAX      = 7'd127;

  typedef enum logic [2:0] {
    M_IDLE,
    M_OPCODE,
    M_PAGE,
    M_BUF,
    M_COPY,
    M_SKIP
  } mode_e;

endpackage

// File: rtl/sfr_pin_sync.sv
module sfr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel,
  output logic sel_start,
  output logic sel_end,
  output logic si_s
);

  localparam int LAST = STAGES - 1;
  localparam logic [2:0] IDLE_PINS = 3'b010; // {sck, cs_n, si}

  logic [2:0] chain [STAGES];
  logic       prev_sck_q;
  logic       prev_cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= IDLE_PINS;
      prev_sck_q <= 1'b0;
      prev_cs_q  <= 1'b1;
    end else begin
      chain[0] <= {sck, cs_n, si};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev_sck_q <= chain[LAST][2];
      prev_cs_q  <= chain[LAST][1];
    end
  end

  assign sck_rise  =  chain[LAST][2] & ~prev_sck_q;
  assign sck_fall  = ~chain[LAST][2] &  prev_sck_q;
  assign sel       = ~chain[LAST][1];
  assign sel_start =  prev_cs_q & ~chain[LAST][1];
  assign sel_end   = ~prev_cs_q &  chain[LAST][1];
  assign si_s      =  chain[LAST][0];

endmodule

// File: rtl/sfr_cmd_engine.sv
module sfr_cmd_engine
  import sfr_pkg::*;
#(
  parameter int  PAGE_BYTES = 264,
  parameter int  NUM_PAGES  = 4,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int PG_W       = $clog2(NUM_PAGES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck_rise,
  input  logic            sck_fall,
  input  logic            sel,
  input  logic            sel_start,
  input  logic            sel_end,
  input  logic            si_s,
  input  logic [7:0]      rd_byte,
  output logic            rd_from_buf,
  output logic [PG_W-1:0] rd_page,
  output logic [OFF_W-1:0] rd_ptr,
  output logic            copy_go,
  output logic [PG_W-1:0] copy_page,
  output logic            so,
  output logic            so_oe
);

  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

  mode_e              mode_q;
  logic [FIELD_W-1:0] sh_q, sh_nx;
  logic [CNT_W-1:0]   cnt_q, cnt_nx;
  logic [OFF_W-1:0]   ptr_q, ptr_nx;
  logic [PG_W-1:0]    page_q;
  logic [2:0]         bit_q;
  logic               stream_q;
  logic               so_q, oe_q;
  logic               go_q;
  logic [PG_W-1:0]    go_page_q;

  function automatic logic [OFF_W-1:0] fold_off(input logic [FIELD_W-1:0] raw);
    return OFF_W'(32'(raw) % 32'(PAGE_BYTES));
  endfunction

  function automatic logic [PG_W-1:0] fold_page(input logic [FIELD_W-1:0] raw);
    return PG_W'(32'(raw) % 32'(NUM_PAGES));
  endfunction

  assign sh_nx  = {sh_q[FIELD_W-2:0], si_s};
  assign cnt_nx = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign ptr_nx = (ptr_q == LAST_OFF) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      ptr_q     <= '0;
      page_q    <= '0;
      bit_q     <= 3'd7;
      stream_q  <= 1'b0;
      so_q      <= 1'b0;
      oe_q      <= 1'b0;
      go_q      <= 1'b0;
      go_page_q <= '0;
    end else begin
      go_q <= 1'b0;
      if (sel_start) begin
        mode_q   <= M_OPCODE;
        cnt_q    <= '0;
        bit_q    <= 3'd7;
        stream_q <= 1'b0;
      end else if (sel_end) begin
        if (mode_q == M_COPY && cnt_q >= AT_COPY_DONE) begin
          go_q      <= 1'b1;
          go_page_q <= page_q;
        end
        mode_q   <= M_IDLE;
        stream_q <= 1'b0;
        oe_q     <= 1'b0;
      end else if (sel) begin
        if (sck_rise) begin
          sh_q  <= sh_nx;
          cnt_q <= cnt_nx;
          unique case (mode_q)
            M_OPCODE: begin
              if (cnt_nx == AT_OPCODE) begin
                unique case (sh_nx[7:0])
                  OP_PAGE_READ: mode_q <= M_PAGE;
                  OP_BUF_READ:  mode_q <= M_BUF;
                  OP_PAGE_COPY: mode_q <= M_COPY;
                  default:      mode_q <= M_SKIP;
                endcase
              end
            end
            M_PAGE: begin
              if (cnt_nx == AT_PAGE)      page_q   <= fold_page(sh_nx);
              if (cnt_nx == AT_OFFSET)    ptr_q    <= fold_off(sh_nx);
              if (cnt_nx == AT_PAGE_DATA) stream_q <= 1'b1;
            end
            M_BUF: begin
              if (cnt_nx == AT_OFFSET)   ptr_q    <= fold_off(sh_nx);
              if (cnt_nx == AT_BUF_DATA) stream_q <= 1'b1;
            end
            M_COPY: begin
              if (cnt_nx == AT_PAGE) page_q <= fold_page(sh_nx);
            end
            default: ;
          endcase
        end
        if (sck_fall && stream_q) begin
          so_q  <= rd_byte[bit_q];
          oe_q  <= 1'b1;
          bit_q <= bit_q - 1'b1;
          if (bit_q == 3'd0) ptr_q <= ptr_nx;
        end
      end
    end
  end

  assign rd_from_buf = (mode_q == M_BUF);
  assign rd_page     = page_q;
  assign rd_ptr      = ptr_q;
  assign copy_go     = go_q;
  assign copy_page   = go_page_q;
  assign so          = so_q;
  assign so_oe       = oe_q;

  // R2: the output bit only moves on a serial-clock falling edge
  p_so_moves_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(so_q));

  // R2, R3, R7: no output before the frame of the active read is complete
  p_no_early_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> ((mode_q == M_PAGE && cnt_q >= AT_PAGE_DATA) ||
              (mode_q == M_BUF  && cnt_q >= AT_BUF_DATA)));

  // R4: the read pointer never leaves the page
  p_ptr_in_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr_q) < 32'(PAGE_BYTES));

  // R10: an unknown opcode keeps the output disabled
  p_skip_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SKIP) |-> !oe_q);

  // R11: a deselected slave does not drive its output
  p_quiet_deselected_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !oe_q);

  // R9: a copy can only be launched as select is released
  p_copy_on_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> !sel);

endmodule

// File: rtl/sfr_store.sv
module sfr_store #(
  parameter int  PAGE_BYTES = 264,
  parameter int  NUM_PAGES  = 4,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int PG_W       = $clog2(NUM_PAGES),
  localparam int MEM_DEPTH  = PAGE_BYTES * NUM_PAGES,
  localparam int MEM_AW     = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [MEM_AW-1:0] pl_addr,
  input  logic [7:0]        pl_data,
  input  logic              copy_go,
  input  logic [PG_W-1:0]   copy_page,
  input  logic              rd_from_buf,
  input  logic [PG_W-1:0]   rd_page,
  input  logic [OFF_W-1:0]  rd_ptr,
  output logic [7:0]        rd_byte
);

  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

  logic [7:0] main_mem [MEM_DEPTH];
  logic [7:0] buf_mem  [PAGE_BYTES];

  logic              busy_q;
  logic [OFF_W-1:0]  idx_q;
  logic [MEM_AW-1:0] base_q;
  logic [MEM_AW-1:0] rd_addr;
  logic              pl_fire;

  function automatic logic [MEM_AW-1:0] page_base(input logic [PG_W-1:0] pg);
    return MEM_AW'(32'(pg) * 32'(PAGE_BYTES));
  endfunction

  assign pl_ready = !busy_q;
  assign pl_fire  = pl_valid && pl_ready && (32'(pl_addr) < 32'(MEM_DEPTH));

  always_ff @(posedge clk) begin
    if (pl_fire) main_mem[pl_addr] <= pl_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
    end else if (busy_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST_OFF) busy_q <= 1'b0;
    end else if (copy_go) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      base_q <= page_base(copy_page);
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q) buf_mem[idx_q] <= main_mem[base_q + MEM_AW'(idx_q)];
  end

  assign rd_addr = page_base(rd_page) + MEM_AW'(rd_ptr);
  assign rd_byte = rd_from_buf ? buf_mem[rd_ptr] : main_mem[rd_addr];

  // R8: a launched copy starts at byte 0 on the next cycle
  p_copy_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_go && !busy_q) |=> (busy_q && idx_q == '0));

  // R8: the copy stops after the last byte of the page
  p_copy_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q == LAST_OFF) |=> !busy_q);

endmodule

// File: rtl/sflash_read_slave.sv
module sflash_read_slave #(
  parameter int  PAGE_BYTES  = 264,
  parameter int  NUM_PAGES   = 4,
  parameter int  SYNC_STAGES = 2,
  localparam int OFF_W       = $clog2(PAGE_BYTES),
  localparam int PG_W        = $clog2(NUM_PAGES),
  localparam int MEM_AW      = $clog2(PAGE_BYTES * NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [MEM_AW-1:0] pl_addr,
  input  logic [7:0]        pl_data
);

  logic             sck_rise, sck_fall, sel, sel_start, sel_end, si_s;
  logic [7:0]       rd_byte;
  logic             rd_from_buf;
  logic [PG_W-1:0]  rd_page;
  logic [OFF_W-1:0] rd_ptr;
  logic             copy_go;
  logic [PG_W-1:0]  copy_page;

  sfr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck       (sck),
    .cs_n      (cs_n),
    .si        (si),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .sel       (sel),
    .sel_start (sel_start),
    .sel_end   (sel_end),
    .si_s      (si_s)
  );

  sfr_cmd_engine #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_rise    (sck_rise),
    .sck_fall    (sck_fall),
    .sel         (sel),
    .sel_start   (sel_start),
    .sel_end     (sel_end),
    .si_s        (si_s),
    .rd_byte     (rd_byte),
    .rd_from_buf (rd_from_buf),
    .rd_page     (rd_page),
    .rd_ptr      (rd_ptr),
    .copy_go     (copy_go),
    .copy_page   (copy_page),
    .so          (so),
    .so_oe       (so_oe)
  );

  sfr_store #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .pl_valid    (pl_valid),
    .pl_ready    (pl_ready),
    .pl_addr     (pl_addr),
    .pl_data     (pl_data),
    .copy_go     (copy_go),
    .copy_page   (copy_page),
    .rd_from_buf (rd_from_buf),
    .rd_page     (rd_page),
    .rd_ptr      (rd_ptr),
    .rd_byte     (rd_byte)
  );

endmodule

// File: tb/tb_sflash_read_slave.sv
module tb_sflash_read_slave;

  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 4;
  localparam int NP         = 4;
  localparam int PB         = 264;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe, pl_ready;
  logic pl_valid = 1'b0;
  logic [10:0] pl_addr = '0;
  logic [7:0]  pl_data = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sflash_read_slave dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe), .pl_valid(pl_valid), .pl_ready(pl_ready),
    .pl_addr(pl_addr), .pl_data(pl_data)
  );

  function automatic logic [7:0] pat(input int p, input int o);
    return 8'((o * 7) + ((o >> 8) * 3) + (p * 29) + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic b, output logic r, output logic oe);
    si = b;
    repeat (SCK_HALF) @(negedge clk);
    r  = so;
    oe = so_oe;
    sck = 1'b1;
    repeat (SCK_HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n, output logic any_oe);
    logic r, oe;
    any_oe = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      xfer(v[i], r, oe);
      any_oe = any_oe | oe;
    end
  endtask

  task automatic read_byte(output logic [7:0] d, output logic all_oe);
    logic r, oe;
    d = '0;
    all_oe = 1'b1;
    for (int i = 0; i < 8; i++) begin
      xfer(1'b0, r, oe);
      d = {d[6:0], r};
      all_oe = all_oe & oe;
    end
  endtask

  task automatic begin_cmd();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (SCK_HALF) @(negedge clk);
  endtask

  task automatic end_cmd();
    repeat (SCK_HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic wait_ready();
    while (!pl_ready) @(negedge clk);
  endtask

  // opcode 0x52 frame: reserved6, page9, offset9, 32 dummy bits
  task automatic open_page_read(input int pg, input int off, input logic [5:0] rsv);
    logic any_oe;
    begin_cmd();
    send(32'h52, 8, any_oe);
    send({8'h0, rsv, 9'(pg), 9'(off)}, 24, any_oe);
    send(32'hDEADBEEF, 32, any_oe);
    check(!any_oe, "R2 silent during 0x52 frame", any_oe, 0);
  endtask

  // opcode 0x54 frame: 15 dummy, addr9, 8 dummy
  task automatic open_buf_read(input int addr);
    logic any_oe;
    begin_cmd();
    send(32'h54, 8, any_oe);
    send(32'h7FFF, 15, any_oe);
    send(32'(9'(addr)), 9, any_oe);
    send(32'hFF, 8, any_oe);
    check(!any_oe, "R2 silent during 0x54 frame", any_oe, 0);
  endtask

  task automatic read_expect(input int n, input int pg, input int start, input bit from_buf,
                             input string req);
    logic [7:0] d;
    logic all_oe;
    for (int i = 0; i < n; i++) begin
      read_byte(d, all_oe);
      check(all_oe, req, all_oe, 1);
      check(d == pat(pg, (start + i) % PB), req, d, pat(pg, (start + i) % PB));
    end
  endtask

  task automatic do_copy(input int pg, input int extra);
    logic any_oe;
    begin_cmd();
    send(32'h53, 8, any_oe);
    send({17'h0, 6'b110011, 9'(pg)}, 15, any_oe);
    send(32'hA5A5A5A5, extra, any_oe);
    end_cmd();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic any_oe;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(so_oe == 1'b0, "R1 so_oe after reset", so_oe, 0);
    check(pl_ready == 1'b1, "R1 pl_ready after reset", pl_ready, 1);

    // R12 preload every byte of every page through the stream
    for (int p = 0; p < NP; p++) begin
      for (int o = 0; o < PB; o++) begin
        wait_ready();
        pl_valid = 1'b1;
        pl_addr  = 11'(p * PB + o);
        pl_data  = pat(p, o);
        @(negedge clk);
      end
    end
    pl_valid = 1'b0;

    // R8 copy page 2 with the minimum 23 bits after the opcode; R12 ready drops
    do_copy(2, 8);
    check(pl_ready == 1'b0, "R12 pl_ready low during copy", pl_ready, 0);
    wait_ready();

    // R7 full buffer read through the wrap point
    open_buf_read(0);
    read_expect(PB + 1, 2, 0, 1'b1, "R7 R8 buffer read with wrap");
    end_cmd();

    // R3 R4 page read across the end of page 1
    open_page_read(1, 260, 6'b101010);
    read_expect(10, 1, 260, 1'b0, "R3 R4 page read wrap");
    end_cmd();

    // R5 offsets folded modulo the page size
    open_page_read(3, 264, 6'h3F);
    read_expect(2, 3, 0, 1'b0, "R5 offset 264");
    end_cmd();
    open_page_read(3, 300, 6'h00);
    read_expect(2, 3, 36, 1'b0, "R5 offset 300");
    end_cmd();
    open_page_read(3, 511, 6'h00);
    read_expect(2, 3, 247, 1'b0, "R5 offset 511");
    end_cmd();

    // R3 page field 6 lands on page 2 with four pages
    open_page_read(6, 5, 6'h00);
    read_expect(2, 2, 5, 1'b0, "R3 page field modulo");
    end_cmd();

    // R4 sweep each page at start, middle and the wrap point
    for (int p = 0; p < NP; p++) begin
      open_page_read(p, 0, 6'h00);
      read_expect(2, p, 0, 1'b0, "R4 sweep start");
      end_cmd();
      open_page_read(p, 131, 6'h00);
      read_expect(2, p, 131, 1'b0, "R4 sweep middle");
      end_cmd();
      open_page_read(p, 262, 6'h00);
      read_expect(3, p, 262, 1'b0, "R4 sweep wrap");
      end_cmd();
    end

    // R6 buffer still holds page 2 after the page reads
    open_buf_read(100);
    read_expect(4, 2, 100, 1'b1, "R6 buffer untouched by 0x52");
    end_cmd();

    // R9 copy aborted after 10 bits: no copy, buffer unchanged
    begin_cmd();
    send(32'h53, 8, any_oe);
    send(32'h0, 10, any_oe);
    end_cmd();
    check(pl_ready == 1'b1, "R9 no copy started", pl_ready, 1);
    open_buf_read(7);
    read_expect(2, 2, 7, 1'b1, "R9 buffer unchanged after abort");
    end_cmd();

    // R10 unknown opcode stays silent
    begin_cmd();
    send(32'hA5, 8, any_oe);
    send(32'h0, 32, any_oe);
    check(!any_oe, "R10 silent after unknown opcode", any_oe, 0);
    send(32'hFFFFFFFF, 32, any_oe);
    send(32'h0, 16, any_oe);
    check(!any_oe, "R10 still silent", any_oe, 0);
    end_cmd();

    // R11 release mid-read, then a fresh command
    open_page_read(0, 0, 6'h00);
    read_expect(2, 0, 0, 1'b0, "R11 read before release");
    end_cmd();
    check(so_oe == 1'b0, "R11 so_oe after release", so_oe, 0);
    open_page_read(0, 3, 6'h00);
    read_expect(1, 0, 3, 1'b0, "R11 next command decoded");
    end_cmd();

    // R8 copy page 0 with extra trailing bits, check wrap of buffer
    do_copy(0, 20);
    wait_ready();
    open_buf_read(263);
    read_expect(2, 0, 263, 1'b1, "R8 R7 buffer holds page 0");
    end_cmd();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule